// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the serial pins of a SPI slave and its protocol engine. It lets the host freeze a transaction in the middle by pulling the active-low pause input low. While the pause lasts, the engine sees no serial clock edges and no data, and the data output driver is turned off. The engine's bit counter and shift register therefore keep their contents, and the transaction resumes where it stopped once the pause input goes high again.

All pins are sampled by the block's system clock, which must be much faster than the serial clock. A pause is only entered or left while the serial clock is low. An edge of the pause input that arrives while the serial clock is high is held back until the next serial clock falling edge, and then applied only if the pause level still calls for the change. The host may deselect the device during a pause. On the next selection the interface is still paused, and the block sends a one-cycle reset request to the protocol engine.

Top module: `spi_hold_gate`

## Requirements
- R1: While chip select `cs_n` is high, edges of `hold_n` have no effect. Selecting the device while `hold_n` is already low does not pause the interface.
- R2: While selected, a falling edge of `hold_n` sampled while `sck` is low pauses the interface from the next system clock cycle.
- R3: While selected and paused, a rising edge of `hold_n` sampled while `sck` is low ends the pause from the next system clock cycle.
- R4: While paused, `sck_rise_en`, `sck_fall_en` and `miso_oe` are 0 and `mosi_gated` is 0, whatever `sck` and `mosi` do.
- R5: A `hold_n` edge sampled while `sck` is high is deferred. At the next `sck` falling edge the pause state takes the value `!hold_n`, from the next cycle. If `hold_n` has returned to its earlier level by then, the pause state does not change.
- R6: `miso_oe` is 1 exactly when `cs_n` is low, the interface is not paused and `out_req` is 1.
- R7: If `cs_n` goes high while paused, the interface stays paused after reselection. `proto_rst` is 1 for exactly one system cycle, in the cycle after the one where `cs_n` is first sampled low again. The pause then ends only through R3.
- R8: A pause with no deselect never raises `proto_rst`, and clock enables resume after the pause ends.
- R9: `sck_rise_en` (resp. `sck_fall_en`) is 1 in the cycle where `sck` is sampled 1 (resp. 0) after being 0 (resp. 1) in the previous cycle, provided the device is selected and not paused. `mosi_gated` follows `mosi` in that state.
- R10: After reset the interface is not paused, `proto_rst` is 0 and no deselect is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| out_req | input | 1 | Protocol engine wants to drive serial data out |
| sck_rise_en | output | 1 | Gated rising-edge strobe for the engine |
| sck_fall_en | output | 1 | Gated falling-edge strobe for the engine |
| mosi_gated | output | 1 | Serial data in, forced low when inactive |
| miso_oe | output | 1 | Output enable for the serial data out driver |
| proto_rst | output | 1 | One-cycle reset request to the protocol engine |

## Verification
Assertions check on every cycle that a pause input edge with the serial clock low changes the pause state on the next cycle, that a deselected device never changes its pause state, that a deferred edge takes effect at the serial clock falling edge, and that a paused interface produces no strobes, no output enable and no data. Assertions also check that the reset request lasts only one cycle. The bench scenarios show the behaviour that depends on history: a deferred edge cancelled before the clock falls, a pause that survives a deselect and reselect, and the fact that an ordinary pause never resets the engine.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  input  logic out_req,
  output logic sck_rise_en,
  output logic sck_fall_en,
  output logic mosi_gated,
  output logic miso_oe,
  output logic proto_rst
);

  logic sck_prev, hold_prev, cs_prev;
  logic paused, pend, lost;

  logic sel, active, hold_edge, sck_fall, apply;

  assign sel       = !cs_n;
  assign active    = sel && !paused;
  assign hold_edge = hold_n ^ hold_prev;
  assign sck_fall  = sck_prev && !sck;
  assign apply     = sel && ((hold_edge && !sck) || (pend && sck_fall));

  assign sck_rise_en = active && sck && !sck_prev;
  assign sck_fall_en = active && sck_fall;
  assign mosi_gated  = active && mosi;
  assign miso_oe     = active && out_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev  <= 1'b0;
      hold_prev <= 1'b1;
      cs_prev   <= 1'b1;
    end else begin
      sck_prev  <= sck;
      hold_prev <= hold_n;
      cs_prev   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused <= 1'b0;
    end else if (apply) begin
      paused <= !hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (!sel || sck_fall) begin
      pend <= 1'b0;
    end else if (hold_edge && sck) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost      <= 1'b0;
      proto_rst <= 1'b0;
    end else begin
      proto_rst <= lost && cs_prev && !cs_n;
      if (paused && cs_n) lost <= 1'b1;
      else if (lost && cs_prev && !cs_n) lost <= 1'b0;
    end
  end

  AST_ENTER_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && hold_prev && !hold_n && !sck) |=> paused); // R2
  AST_EXIT_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !hold_prev && hold_n && !sck) |=> !paused); // R3
  AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(paused)); // R1
  AST_DEFER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && pend && sck_prev && !sck) |=> (paused == $past(!hold_n))); // R5
  AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !(sck_rise_en || sck_fall_en || miso_oe || mosi_gated)); // R4
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_rst |=> !proto_rst); // R7

endmodule

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, out_req = 1'b0;
  logic sck_rise_en, sck_fall_en, mosi_gated, miso_oe, proto_rst;
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  spi_hold_gate uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .out_req(out_req), .sck_rise_en(sck_rise_en),
    .sck_fall_en(sck_fall_en), .mosi_gated(mosi_gated), .miso_oe(miso_oe),
    .proto_rst(proto_rst)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, look 1 ns later (before the next posedge)
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    step();
    chk("R10 proto_rst", proto_rst, 1'b0);
    rst_n = 1'b1;
    cs_n = 1'b0; out_req = 1'b1; step();
    chk("R10 not paused oe", miso_oe, 1'b1);
  endtask

  task automatic t_normal();
    @(negedge clk); sck = 1'b1; mosi = 1'b1; #1;
    chk("R9 rise_en", sck_rise_en, 1'b1);
    chk("R9 mosi_gated", mosi_gated, 1'b1);
    step();
    chk("R9 rise_en one cycle", sck_rise_en, 1'b0);
    @(negedge clk); sck = 1'b0; #1;
    chk("R9 fall_en", sck_fall_en, 1'b1);
    @(negedge clk); out_req = 1'b0; #1;
    chk("R6 oe off without request", miso_oe, 1'b0);
    @(negedge clk); out_req = 1'b1; #1;
    chk("R6 oe on", miso_oe, 1'b1);
  endtask

  task automatic t_plain_hold();
    @(negedge clk); hold_n = 1'b0; #1;
    chk("R2 active in edge cycle", miso_oe, 1'b1);
    step();
    chk("R2 paused oe", miso_oe, 1'b0);
    chk("R4 mosi gated", mosi_gated, 1'b0);
    @(negedge clk); sck = 1'b1; #1;
    chk("R4 no rise_en", sck_rise_en, 1'b0);
    @(negedge clk); sck = 1'b0; #1;
    chk("R4 no fall_en", sck_fall_en, 1'b0);
    @(negedge clk); hold_n = 1'b1; step();
    chk("R3 resumed oe", miso_oe, 1'b1);
    @(negedge clk); sck = 1'b1; #1;
    chk("R8 rise_en after pause", sck_rise_en, 1'b1);
    chk("R8 no proto_rst", proto_rst, 1'b0);
  endtask

  task automatic t_deferred();
    // sck is high here
    @(negedge clk); hold_n = 1'b0; step(); step();
    chk("R5 still active while sck high", miso_oe, 1'b1);
    @(negedge clk); sck = 1'b0; step();
    chk("R5 paused after sck fall", miso_oe, 1'b0);
    @(negedge clk); sck = 1'b1; step();
    @(negedge clk); hold_n = 1'b1; step();
    chk("R5 exit deferred", miso_oe, 1'b0);
    @(negedge clk); sck = 1'b0; step();
    chk("R5 resumed after sck fall", miso_oe, 1'b1);
    @(negedge clk); sck = 1'b1; step();
    @(negedge clk); hold_n = 1'b0; step();
    @(negedge clk); hold_n = 1'b1; step();
    @(negedge clk); sck = 1'b0; step();
    chk("R5 cancelled edge no pause", miso_oe, 1'b1);
  endtask

  task automatic t_deselected_edges();
    @(negedge clk); cs_n = 1'b1; step();
    @(negedge clk); hold_n = 1'b0; step();
    @(negedge clk); cs_n = 1'b0; step(); step();
    chk("R1 no pause from deselected edge", miso_oe, 1'b1);
    @(negedge clk); hold_n = 1'b1; step();
    chk("R1 still active", miso_oe, 1'b1);
  endtask

  task automatic t_deselect_in_hold();
    @(negedge clk); hold_n = 1'b0; step(); step();
    chk("R7 paused", miso_oe, 1'b0);
    @(negedge clk); cs_n = 1'b1; step(); step();
    @(negedge clk); hold_n = 1'b1; step();
    chk("R7 no rst while deselected", proto_rst, 1'b0);
    @(negedge clk); cs_n = 1'b0; #1;
    chk("R7 no rst in select cycle", proto_rst, 1'b0);
    step();
    chk("R7 rst pulse", proto_rst, 1'b1);
    chk("R7 still paused", miso_oe, 1'b0);
    step();
    chk("R7 rst one cycle", proto_rst, 1'b0);
    chk("R7 paused after reselect", miso_oe, 1'b0);
    @(negedge clk); hold_n = 1'b0; step();
    @(negedge clk); hold_n = 1'b1; step();
    chk("R7 resume through R3", miso_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_normal();
    @(negedge clk); sck = 1'b0; step();
    t_plain_hold();
    t_deferred();
    t_deselected_edges();
    t_deselect_in_hold();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule